// File: doc/BRIEF.md
# Buffered Program Sequencer

This block sits behind a command decoder and runs the buffered programming path of a NOR-style flash array model. Its sequence opens with a setup command that names a target block. It then accepts a word count and that many address/data loads into a small staging buffer. A confirm command ends the loading. After the confirm, the block copies the staged words into the array one at a time. While it loads, it shows on a separate flag whether the staging buffer is free. While it copies, it shows on the main status byte that it is busy.

Writes that break the sequence are rejected, and none of them reaches the array. This covers an oversized count, a load that points outside the setup block, and any command other than confirm after the last load. A rejection raises two error bits in the status byte.

The array copy behaves like flash programming, which can only pull bits from 1 to 0. Each target word is read, ANDed with the staged data and written back.

Top module: `bufprog_seq`

## Requirements
- R1: After synchronous reset, `stat` is 0x80, `buf_free` is 1 and `mem_we` is 0.
- R2: While idle, only a bus write with `bus_data[7:0]` = 0xE8 starts a sequence, and the block it targets is `bus_addr[7:4]`. Any other idle write leaves `stat`, `buf_free` and the array unchanged.
- R3: `buf_free` is 1 while idle and while waiting for the count. It is 0 from the cycle after an accepted count until the sequence ends or is rejected.
- R4: The write after setup carries the count minus one in `bus_data[7:0]`. A value above 15 (for example 16) is rejected: `stat` becomes 0xB0 (bit 7 ready, bits 5 and 4 error) and the array is untouched.
- R5: A data load whose `bus_addr[7:4]` differs from the setup block is rejected with `stat` = 0xB0. No word of that sequence is written.
- R6: After the last load, a write with `bus_data[7:0]` = 0xD0 starts the copy. Any other value is rejected with `stat` = 0xB0 and no array write.
- R7: During the copy, `stat[7]` is 0 and bus writes are ignored. When the last word has been written, `stat[7]` returns to 1 and the block is idle.
- R8: Load i goes to its own load address. The value written is the old array word ANDed with the staged data. Words go in load order, one write every two cycles, so the copy is busy for 2N cycles.
- R9: The error bits stay set until the next accepted setup command, which clears them, so `stat` reads 0x80 after it.
- R10: The buffer holds 16 words. A count field of 15 is accepted and all 16 loads are copied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 8 | Bus word address |
| bus_data | input | 16 | Bus write data or command byte in [7:0] |
| buf_free | output | 1 | Extended status: staging buffer free |
| stat | output | 8 | Status byte: bit 7 ready, bits 5 and 4 sequence error |
| mem_raddr | output | 8 | Array read address (1-cycle synchronous read) |
| mem_rdata | input | 16 | Array read data |
| mem_we | output | 1 | Array write enable |
| mem_waddr | output | 8 | Array write address |
| mem_wdata | output | 16 | Array write data (old AND new) |

## Verification
The bench uses the default parameters: an 8-bit word address, 4-bit in-block offsets and a 16-word buffer. That gives sixteen blocks of sixteen words, so one full buffer covers a whole block. The array is small enough to compare in full against a scoreboard after every sequence, whether the sequence was accepted or rejected. With these sizes the count boundary between 15 and 16 is reachable. So are repeated loads to one address within a sequence, which exercise the AND merge, and a load into the neighbouring block.

// File: rtl/bufprog_pkg.sv
package bufprog_pkg;
  localparam logic [7:0] CMD_SETUP   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  typedef enum logic [2:0] {
    S_IDLE, S_CNT, S_LOAD, S_CONF, S_RD, S_WR
  } seq_state_t;
endpackage

// File: rtl/bufprog_ram.sv
module bufprog_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 20,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdat,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdat
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[widx] <= wdat;
  end

  assign rdat = store[ridx];
endmodule

// File: rtl/bufprog_fsm.sv
module bufprog_fsm
  import bufprog_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int BLK_BITS  = 4,
  parameter int BUF_WORDS = 16,
  localparam int IW       = $clog2(BUF_WORDS),
  localparam int BW       = AW - BLK_BITS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_data,
  output logic                   buf_we,
  output logic [IW-1:0]          buf_idx,
  output logic [BLK_BITS+DW-1:0] buf_wentry,
  input  logic [BLK_BITS+DW-1:0] buf_rentry,
  output logic                   busy,
  output logic                   free,
  output logic                   err,
  output logic [AW-1:0]          mem_raddr,
  input  logic [DW-1:0]          mem_rdata,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_waddr,
  output logic [DW-1:0]          mem_wdata
);
  localparam logic [7:0] MAXCNT = 8'(BUF_WORDS - 1);

  seq_state_t    state;
  logic          err_q;
  logic [BW-1:0] blk_q;
  logic [IW-1:0] cnt_q;
  logic [IW-1:0] idx_q;

  logic blk_ok;
  logic last;
  assign blk_ok = (bus_addr[AW-1:BLK_BITS] == blk_q);
  assign last   = (idx_q == cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      err_q <= 1'b0;
      blk_q <= '0;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (bus_we && bus_data[7:0] == CMD_SETUP) begin
          state <= S_CNT;
          blk_q <= bus_addr[AW-1:BLK_BITS];
          err_q <= 1'b0;
        end
        S_CNT: if (bus_we) begin
          if (bus_data[7:0] > MAXCNT) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else begin
            cnt_q <= bus_data[IW-1:0];
            idx_q <= '0;
            state <= S_LOAD;
          end
        end
        S_LOAD: if (bus_we) begin
          if (!blk_ok) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else if (last) begin
            state <= S_CONF;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_CONF: if (bus_we) begin
          if (bus_data[7:0] == CMD_CONFIRM) begin
            idx_q <= '0;
            state <= S_RD;
          end else begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_RD: state <= S_WR;
        S_WR: begin
          if (last) state <= S_IDLE;
          else begin
            idx_q <= idx_q + 1'b1;
            state <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // buffer staging
  assign buf_we     = (state == S_LOAD) && bus_we && blk_ok;
  assign buf_idx    = idx_q;
  assign buf_wentry = {bus_addr[BLK_BITS-1:0], bus_data};

  // array copy: read old word, then write old AND new
  assign mem_raddr = {blk_q, buf_rentry[BLK_BITS+DW-1:DW]};
  assign mem_waddr = mem_raddr;
  assign mem_we    = (state == S_WR);
  assign mem_wdata = mem_rdata & buf_rentry[DW-1:0];

  assign busy = (state == S_RD) || (state == S_WR);
  assign free = (state == S_IDLE) || (state == S_CNT);
  assign err  = err_q;

  // R1: reset leaves the sequencer idle with no error
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (state == S_IDLE && !err_q));

  // R4/R5/R6: an error can only appear in answer to a bus write
  p_err_from_bus_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(bus_we));

  // R6: confirm in the confirm state starts the copy
  p_confirm_starts_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_CONF && bus_we && bus_data[7:0] == CMD_CONFIRM) |=> busy);

  // R7: error flag does not move while copying
  p_busy_err_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(err_q));

  // R8: array writes are never back to back
  p_write_spacing_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R9: accepted setup clears the error flags
  p_setup_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && bus_we && bus_data[7:0] == CMD_SETUP) |=> !err_q);

  // R10: the index never passes the accepted count
  p_idx_bound_r10: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && state != S_CNT) |-> (idx_q <= cnt_q));
endmodule

// File: rtl/bufprog_seq.sv
module bufprog_seq #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int BLK_BITS  = 4,
  parameter int BUF_WORDS = 16,
  localparam int IW       = $clog2(BUF_WORDS),
  localparam int EW       = BLK_BITS + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic          buf_free,
  output logic [7:0]    stat,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);
  logic          buf_we;
  logic [IW-1:0] buf_idx;
  logic [EW-1:0] buf_wentry;
  logic [EW-1:0] buf_rentry;
  logic          busy;
  logic          err;

  bufprog_fsm #(
    .AW(AW), .DW(DW), .BLK_BITS(BLK_BITS), .BUF_WORDS(BUF_WORDS)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_data(bus_data),
    .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_wentry(buf_wentry), .buf_rentry(buf_rentry),
    .busy(busy), .free(buf_free), .err(err),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  bufprog_ram #(.DEPTH(BUF_WORDS), .W(EW)) u_ram (
    .clk(clk), .we(buf_we), .widx(buf_idx), .wdat(buf_wentry),
    .ridx(buf_idx), .rdat(buf_rentry)
  );

  // status byte: bit 7 ready, bits 5 and 4 sequence error
  assign stat = {~busy, 1'b0, err, err, 4'b0000};
endmodule

// File: tb/bufprog_seq_bench.sv
`timescale 1ns/1ps
module bufprog_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic        buf_free;
  logic [7:0]  stat;
  logic [7:0]  mem_raddr, mem_waddr;
  logic [15:0] mem_rdata, mem_wdata;
  logic        mem_we;

  int checks = 0;
  int fails  = 0;
  int busy_cyc = 0;
  int we_cnt = 0;

  logic [15:0] mem [256];
  logic [15:0] sb  [256];

  always #4 clk = ~clk;

  bufprog_seq u_bufprog_seq (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_data(bus_data), .buf_free(buf_free), .stat(stat),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  // array model: erased to all ones, 1-cycle synchronous read
  always @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < 256; a++) mem[a] <= 16'hFFFF;
      mem_rdata <= '0;
    end else begin
      mem_rdata <= mem[mem_raddr];
      if (mem_we) mem[mem_waddr] <= mem_wdata;
    end
  end

  always @(posedge clk) if (!rst && mem_we) we_cnt <= we_cnt + 1;
  always @(negedge clk) if (!rst && !stat[7]) busy_cyc <= busy_cyc + 1;

  // each vector: {kind[1:0], blk[3:0], n[4:0], seed[15:0]}
  // kind 0 good, 1 oversize count, 2 foreign block load, 3 bad confirm
  localparam logic [26:0] VEC [8] = '{
    {2'd0, 4'd2,  5'd4,  16'hA5C3},
    {2'd0, 4'd2,  5'd3,  16'h0F71},
    {2'd1, 4'd5,  5'd1,  16'h0003},
    {2'd0, 4'd5,  5'd1,  16'h1234},
    {2'd2, 4'd7,  5'd3,  16'h4444},
    {2'd0, 4'd15, 5'd16, 16'h8001},
    {2'd3, 4'd0,  5'd2,  16'h7777},
    {2'd0, 4'd0,  5'd8,  16'h3C3C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== sb[a]) bad++;
    chk(req, bad, 0);
  endtask

  task automatic run_seq(input int kind, input int blk, input int n,
                         input logic [15:0] seed, input bit poke);
    logic [7:0]  pa [16];
    logic [15:0] pd [16];
    int b0, w0;
    bus_write(8'(blk << 4), 16'h00E8);
    chk("R9 setup clears status", stat, 8'h80);
    chk("R3 free after setup", buf_free, 1);
    if (kind == 1) begin
      bus_write(8'h00, 16'(16 + seed[2:0]));
      chk("R4 oversize count status", stat, 8'hB0);
      chk("R3 free after reject", buf_free, 1);
      compare_mem("R4 array untouched");
      return;
    end
    bus_write(8'h00, 16'(n - 1));
    chk("R3 not free while loading", buf_free, 0);
    for (int i = 0; i < n; i++) begin
      int off = (i * 5 + int'(seed[3:0])) % 16;
      pd[i] = seed ^ 16'(i * 16'h1357) ^ 16'h0F0F;
      if (kind == 2 && i == n - 1) pa[i] = 8'((((blk + 1) % 16) << 4) | off);
      else pa[i] = 8'((blk << 4) | off);
      bus_write(pa[i], pd[i]);
    end
    if (kind == 2) begin
      chk("R5 foreign block status", stat, 8'hB0);
      compare_mem("R5 array untouched");
      return;
    end
    if (kind == 3) begin
      bus_write(8'(blk << 4), 16'h00FF);
      chk("R6 bad confirm status", stat, 8'hB0);
      compare_mem("R6 array untouched");
      return;
    end
    b0 = busy_cyc; w0 = we_cnt;
    bus_write(8'(blk << 4), 16'h00D0);
    chk("R7 busy after confirm", stat, 8'h00);
    if (poke) bus_write(8'(blk << 4), 16'h00E8);
    for (int t = 0; t < 200 && !stat[7]; t++) @(negedge clk);
    chk("R7 ready after copy", stat, 8'h80);
    chk("R8 busy length 2N", busy_cyc - b0, 2 * n);
    chk("R8 one write per word", we_cnt - w0, n);
    for (int i = 0; i < n; i++) sb[pa[i]] = sb[pa[i]] & pd[i];
    compare_mem(n == 16 ? "R10 full buffer array" : "R8 array merge");
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R7 watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) sb[a] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status after reset", stat, 8'h80);
    chk("R1 free after reset", buf_free, 1);
    chk("R1 no write after reset", mem_we, 0);

    // R2: idle writes other than setup are ignored
    bus_write(8'h30, 16'h00D0);
    bus_write(8'h31, 16'h0003);
    chk("R2 idle status", stat, 8'h80);
    chk("R2 idle free", buf_free, 1);
    chk("R2 idle no array write", we_cnt, 0);
    compare_mem("R2 array untouched");

    // table walk
    for (int v = 0; v < 8; v++) begin
      logic [26:0] e = VEC[v];
      run_seq(int'(e[26:25]), int'(e[24:21]), int'(e[20:16]), e[15:0], 1'b0);
    end

    // R4 boundary: count field of exactly 16 is rejected
    bus_write(8'h90, 16'h00E8);
    bus_write(8'h00, 16'h0010);
    chk("R4 count 16 rejected", stat, 8'hB0);
    // R9: error persists across ignored idle writes
    bus_write(8'h90, 16'h0055);
    chk("R9 error persists", stat, 8'hB0);

    // R7: writes during copy are ignored
    run_seq(0, 9, 4, 16'h6A6A, 1'b1);
    bus_write(8'h90, 16'h0003);
    chk("R7 setup during copy ignored", buf_free, 1);
    chk("R7 status after ignored", stat, 8'h80);

    // R10: second full buffer on same block merges
    run_seq(0, 15, 16, 16'h5A5A, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule